// File: doc/BRIEF.md
# Disk Sector Write Formatter

This block produces the full serial bit stream that is written to one disk sector. A start pulse launches a sector. From then on, every clock cycle with the bit-enable input high sends out exactly one bit. The bits are grouped into these fields, in order:

- a run-in of zeros closed by a single marker one;
- a 37-bit addressed header built from the cylinder, head and sector inputs;
- a zero gap;
- a synchronisation area;
- 128 data words, each followed by an odd parity bit;
- an odd longitudinal parity word with its own parity bit;
- a word of guard bits.

Data words come from a 36-bit word input. The block takes a word on the bit-enable cycle that sends the word's first bit, if the source shows ready in that cycle. If the source is not ready, the block sends zeros for that word and pulses a timing-error output.

A mode input, sampled with the start pulse, selects header write or header keep. In header write, the block writes the header itself. In header keep, the block counts through the run-in, marker, header and gap bit times with the write gate off. The header already on the disk is therefore left intact. The write gate turns on at the synchronisation area.

The sequence is run by a state machine with these states and transitions:

- IDLE goes to PRE on start.
- PRE goes to MARK after 1109 bits.
- MARK goes to HDR after 1 bit.
- HDR goes to GAP after 37 bits.
- GAP goes to SYNC after 37 bits.
- SYNC goes to DATA after 148 bits.
- DATA loops once per 37-bit frame and goes to LPW after the 128th word.
- LPW goes to GUARD after 37 bits.
- GUARD goes to IDLE after 37 bits and raises done on its final bit.

Top module: `sector_write_formatter`

## Requirements
- R1: After reset, ser_bit, wr_gate, busy, done and timing_err are all 0.
- R2: In header-write mode (fmt_mode=1 at start), the first 1109 emitted bits are 0 and the 1110th is 1, all with wr_gate=1.
- R3: The header frame follows the marker and is sent bit 0 first. Bits 0..17 are 0, bits 18..25 hold cyl, bits 26..30 hold head, bit 31 is 0, bits 32..35 hold sect, and bit 36 makes the ones count over bits 0..36 odd.
- R4: After the header come 37 zero bits. Then come 148 synchronisation bits, of which only the last is 1.
- R5: Each data frame is the 36-bit word sent bit 0 first, followed by an odd parity bit. wd_take is high on the bit_en cycle that sends a frame's first bit when wd_ready is high, and the word on wd_data in that cycle is the one sent.
- R6: After the 128th data frame comes a frame whose bit i (i = 0..35) makes the ones count at position i odd over all 128 data words and itself. This frame is followed by its own odd parity bit.
- R7: The sector ends with 37 zero guard bits at wr_gate=1. done is high for one cycle right after the final bit is sent. One cycle later, busy and wr_gate are 0.
- R8: In header-keep mode (fmt_mode=0 at start), the bit times of run-in, marker, header and gap are emitted with wr_gate=0 and ser_bit=0. Everything from the synchronisation area on is the same as in header-write mode.
- R9: If wd_ready is low on a frame's first bit, the word is sent as 36 zeros with parity 1 and is counted as zero in the longitudinal parity. timing_err pulses for one cycle, and wd_take stays low.
- R10: While busy, a cycle with bit_en low leaves ser_bit and wr_gate unchanged and does not advance the stream.
- R11: A start pulse while busy has no effect on the bit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One bit is sent per cycle with this high |
| start | input | 1 | Begin a sector when idle |
| fmt_mode | input | 1 | 1 = write header, 0 = keep existing header |
| cyl | input | 8 | Cylinder address for the header |
| head | input | 5 | Head address for the header |
| sect | input | 4 | Sector address for the header |
| wd_data | input | 36 | Next data word |
| wd_ready | input | 1 | wd_data holds a valid word |
| wd_take | output | 1 | Word on wd_data is consumed this cycle |
| ser_bit | output | 1 | Serial bit to the encoder |
| wr_gate | output | 1 | Write current enable |
| busy | output | 1 | A sector is in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| timing_err | output | 1 | One-cycle pulse for a word that was not ready |

## Verification
The assertions take for granted that cyl, head, sect and fmt_mode are held steady from the start pulse until the header has been sent. They also take for granted that wd_data stays stable from the cycle that shows wd_take until the clock edge that consumes it. The bench drives every input on the falling edge and changes the data word only on the falling edge after a consumption. It keeps the header fields fixed for a whole sector. Its readiness scenario lowers wd_ready only across whole frame boundaries.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_MARK,
        S_HDR,
        S_GAP,
        S_SYNC,
        S_DATA,
        S_LPW,
        S_GUARD
    } sfw_state_t;
endpackage

// File: rtl/sfw_hdr_build.sv
module sfw_hdr_build #(
    parameter int WORD_BITS = 36,
    parameter int CYL_W     = 8,
    parameter int HEAD_W    = 5,
    parameter int SECT_W    = 4
) (
    input  logic [CYL_W-1:0]   cyl,
    input  logic [HEAD_W-1:0]  head,
    input  logic [SECT_W-1:0]  sect,
    output logic [WORD_BITS:0] frame
);
    localparam int LOW_ZEROS = WORD_BITS - CYL_W - HEAD_W - 1 - SECT_W;

    logic [WORD_BITS-1:0] body;

    always_comb begin
        body  = {sect, 1'b0, head, cyl, {LOW_ZEROS{1'b0}}};
        frame = {~^body, body};
    end
endmodule

// File: rtl/sfw_lpar_acc.sv
module sfw_lpar_acc #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] word,
    output logic [W-1:0] lp_word
);
    logic [W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q ^ word;
        end
    end

    assign lp_word = ~acc_q;
endmodule

// File: rtl/sector_write_formatter.sv
module sector_write_formatter
    import sfw_pkg::*;
#(
    parameter int WORD_BITS  = 36,
    parameter int DATA_WORDS = 128,
    parameter int PRE_ZEROS  = 1109,
    parameter int GAP_BITS   = 37,
    parameter int SYNC_WORDS = 4,
    parameter int CYL_W      = 8,
    parameter int HEAD_W     = 5,
    parameter int SECT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 start,
    input  logic                 fmt_mode,
    input  logic [CYL_W-1:0]     cyl,
    input  logic [HEAD_W-1:0]    head,
    input  logic [SECT_W-1:0]    sect,
    input  logic [WORD_BITS-1:0] wd_data,
    input  logic                 wd_ready,
    output logic                 wd_take,
    output logic                 ser_bit,
    output logic                 wr_gate,
    output logic                 busy,
    output logic                 done,
    output logic                 timing_err
);
    localparam int FRAME_BITS = WORD_BITS + 1;
    localparam int SYNC_BITS  = SYNC_WORDS * FRAME_BITS;
    localparam int CNT_MAX    = (PRE_ZEROS > SYNC_BITS) ? PRE_ZEROS : SYNC_BITS;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int WCNT_W     = $clog2(DATA_WORDS + 1);

    sfw_state_t              state_q, state_d;
    logic [CNT_W-1:0]        cnt_q;
    logic [WCNT_W-1:0]       wcnt_q;
    logic                    keep_q;
    logic [FRAME_BITS-1:0]   sh_q;

    logic                    step;
    logic                    seg_end;
    logic                    framed;
    logic                    load_now;
    logic                    gate_now;
    logic                    cur_bit;
    logic [WORD_BITS-1:0]    dword;
    logic [WORD_BITS-1:0]    lp_word;
    logic [FRAME_BITS-1:0]   hdr_frame;
    logic [FRAME_BITS-1:0]   frame_in;

    sfw_hdr_build #(
        .WORD_BITS (WORD_BITS),
        .CYL_W     (CYL_W),
        .HEAD_W    (HEAD_W),
        .SECT_W    (SECT_W)
    ) hdr_i (
        .cyl   (cyl),
        .head  (head),
        .sect  (sect),
        .frame (hdr_frame)
    );

    sfw_lpar_acc #(
        .W (WORD_BITS)
    ) lpar_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == S_IDLE),
        .en      (load_now && (state_q == S_DATA)),
        .word    (dword),
        .lp_word (lp_word)
    );

    // Segment bookkeeping
    always_comb begin
        step   = bit_en && (state_q != S_IDLE);
        framed = (state_q == S_HDR) || (state_q == S_DATA) || (state_q == S_LPW);
        unique case (state_q)
            S_PRE:   seg_end = (cnt_q == CNT_W'(PRE_ZEROS - 1));
            S_MARK:  seg_end = 1'b1;
            S_GAP:   seg_end = (cnt_q == CNT_W'(GAP_BITS - 1));
            S_SYNC:  seg_end = (cnt_q == CNT_W'(SYNC_BITS - 1));
            S_HDR, S_DATA, S_LPW, S_GUARD:
                     seg_end = (cnt_q == CNT_W'(FRAME_BITS - 1));
            default: seg_end = 1'b0;
        endcase
        load_now = step && framed && (cnt_q == '0);
        dword    = wd_ready ? wd_data : '0;
        wd_take  = load_now && (state_q == S_DATA) && wd_ready;
        busy     = (state_q != S_IDLE);
    end

    // Frame source and bit selection
    always_comb begin
        unique case (state_q)
            S_HDR:   frame_in = hdr_frame;
            S_LPW:   frame_in = {~^lp_word, lp_word};
            default: frame_in = {~^dword, dword};
        endcase
        unique case (state_q)
            S_MARK:  cur_bit = 1'b1;
            S_SYNC:  cur_bit = (cnt_q == CNT_W'(SYNC_BITS - 1));
            S_HDR, S_DATA, S_LPW:
                     cur_bit = load_now ? frame_in[0] : sh_q[0];
            default: cur_bit = 1'b0;
        endcase
        gate_now = !(keep_q && ((state_q == S_PRE) || (state_q == S_MARK) ||
                                (state_q == S_HDR) || (state_q == S_GAP)));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)            state_d = S_PRE;
            S_PRE:   if (step && seg_end)  state_d = S_MARK;
            S_MARK:  if (step)             state_d = S_HDR;
            S_HDR:   if (step && seg_end)  state_d = S_GAP;
            S_GAP:   if (step && seg_end)  state_d = S_SYNC;
            S_SYNC:  if (step && seg_end)  state_d = S_DATA;
            S_DATA:  if (step && seg_end && (wcnt_q == WCNT_W'(DATA_WORDS - 1)))
                                           state_d = S_LPW;
            S_LPW:   if (step && seg_end)  state_d = S_GUARD;
            S_GUARD: if (step && seg_end)  state_d = S_IDLE;
            default:                       state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_bit    <= 1'b0;
            wr_gate    <= 1'b0;
            done       <= 1'b0;
            timing_err <= 1'b0;
            cnt_q      <= '0;
            wcnt_q     <= '0;
            keep_q     <= 1'b0;
            sh_q       <= '0;
        end else begin
            done       <= 1'b0;
            timing_err <= 1'b0;
            if (state_q == S_IDLE) begin
                ser_bit <= 1'b0;
                wr_gate <= 1'b0;
                cnt_q   <= '0;
                wcnt_q  <= '0;
                if (start) begin
                    keep_q <= !fmt_mode;
                end
            end else if (step) begin
                ser_bit <= gate_now & cur_bit;
                wr_gate <= gate_now;
                sh_q    <= load_now ? (frame_in >> 1) : (sh_q >> 1);
                cnt_q   <= seg_end ? '0 : cnt_q + 1'b1;
                if ((state_q == S_DATA) && seg_end) begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
                if ((state_q == S_DATA) && load_now && !wd_ready) begin
                    timing_err <= 1'b1;
                end
                if ((state_q == S_GUARD) && seg_end) begin
                    done <= 1'b1;
                end
            end
        end
    end

    // Assertions
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !wr_gate == 1'b0); // R7
    AST_DONE_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_gate); // R7
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_en) |=> ($stable(ser_bit) && $stable(wr_gate))); // R10
    AST_TERR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |-> $past(!wd_ready && bit_en)); // R9
    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gate |-> !ser_bit); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timing_err})); // R9
    AST_TAKE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_take |-> busy && bit_en); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done)); // R11
endmodule

// File: tb/sector_write_formatter_tb.sv
`timescale 1ns/1ps
module sector_write_formatter_tb_top;
    localparam int PRE   = 1109;
    localparam int DSTART = 1110 + 37 + 37 + 148;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        start = 1'b0;
    logic        fmt_mode = 1'b1;
    logic [7:0]  cyl = '0;
    logic [4:0]  head = '0;
    logic [3:0]  sect = '0;
    logic [35:0] wd_data = '0;
    logic        wd_ready = 1'b0;
    logic        wd_take, ser_bit, wr_gate, busy, done, timing_err;

    always #2.5 clk = ~clk;

    sector_write_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .fmt_mode(fmt_mode), .cyl(cyl), .head(head), .sect(sect),
        .wd_data(wd_data), .wd_ready(wd_ready), .wd_take(wd_take),
        .ser_bit(ser_bit), .wr_gate(wr_gate), .busy(busy), .done(done),
        .timing_err(timing_err)
    );

    int checks = 0;
    int errors = 0;

    // scoreboard item: {gate, bit, tag}
    typedef struct packed { logic g; logic b; logic [3:0] tag; } exp_t;
    exp_t exp_q[$];

    logic run_on = 1'b0, half = 1'b0, ready_mode = 1'b0;
    logic en_prev = 1'b0, busy_prev = 1'b0, take_pend = 1'b0;
    logic prev_bit = 1'b0, prev_gate = 1'b0;
    int   take_idx = 0, take_cnt = 0, done_cnt = 0, terr_cnt = 0, bits_seen = 0;

    function automatic logic [35:0] gen(int k);
        if (k == 3) return '1;
        if (k == 4) return '0;
        return (36'(k) * 36'd2654435761) ^ 36'hA5C3_0F1E5;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic g, logic b, logic [3:0] tag);
        exp_t e;
        e.g = g; e.b = g & b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // driver: expected stream per requirements
    task automatic build(logic fmt, int pad);
        logic [35:0] body, acc, w;
        logic g;
        g = fmt;
        for (int i = 0; i < PRE; i++) push(g, 1'b0, 4'd2);          // R2
        push(g, 1'b1, 4'd2);                                          // R2
        body = {sect, 1'b0, head, cyl, 18'b0};                        // R3
        for (int i = 0; i < 36; i++) push(g, body[i], 4'd3);
        push(g, ~^body, 4'd3);
        for (int i = 0; i < 37; i++) push(g, 1'b0, 4'd4);             // R4 gap
        for (int i = 0; i < 148; i++) push(1'b1, (i == 147), 4'd4);   // R4 sync
        acc = '0;
        for (int j = 0; j < 128; j++) begin                           // R5
            w = (j < pad) ? 36'b0 : gen(j - pad);
            acc ^= w;
            for (int i = 0; i < 36; i++) push(1'b1, w[i], 4'd5);
            push(1'b1, ~^w, 4'd5);
        end
        w = ~acc;                                                     // R6
        for (int i = 0; i < 36; i++) push(1'b1, w[i], 4'd6);
        push(1'b1, ~^w, 4'd6);
        for (int i = 0; i < 37; i++) push(1'b1, 1'b0, 4'd7);          // R7
    endtask

    // monitor
    always @(negedge clk) begin
        if (run_on) begin
            if (en_prev && busy_prev) begin
                exp_t e;
                string rq;
                if (exp_q.size() == 0) begin
                    check("R11 extra bit", 64'd1, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    rq = $sformatf("R%0d bit %0d", e.tag, bits_seen);
                    if (!fmt_mode && e.tag <= 4'd3) rq = {"R8 ", rq};
                    if (half && wd_ready == 1'b0) rq = {"R9 ", rq};
                    check(rq, {62'b0, wr_gate, ser_bit}, {62'b0, e.g, e.b});
                    if (exp_q.size() == 0) check("R7 done on last bit", done, 1);
                end
                bits_seen++;
            end else if (busy_prev) begin
                check("R10 hold", {62'b0, wr_gate, ser_bit}, {62'b0, prev_gate, prev_bit});
            end
            if (timing_err) terr_cnt++;
            if (done) done_cnt++;
            if (take_pend) begin
                take_idx++;
                wd_data = gen(take_idx);
                take_pend = 1'b0;
            end
            if (ready_mode) wd_ready = (bits_seen >= DSTART + 37 + 5);
            bit_en = half ? ~bit_en : 1'b1;
            busy_prev = busy;
            prev_bit = ser_bit;
            prev_gate = wr_gate;
            #1;
            en_prev = bit_en;
            if (wd_take) begin
                take_pend = 1'b1;
                take_cnt++;
            end
        end
    end

    task automatic run_sector(logic fmt, logic hf, logic rmode, int pad,
                              logic [7:0] c, logic [4:0] h, logic [3:0] s, logic poke);
        @(negedge clk);
        fmt_mode = fmt; half = hf; ready_mode = rmode;
        cyl = c; head = h; sect = s;
        take_idx = 0; take_cnt = 0; done_cnt = 0; terr_cnt = 0; bits_seen = 0;
        take_pend = 1'b0;
        wd_data = gen(0);
        wd_ready = !rmode;
        build(fmt, pad);
        run_on = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;                                             // R11
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R7 idle busy", busy, 0);
        check("R7 idle gate", wr_gate, 0);
        check("R7 one done", done_cnt, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 ser_bit", ser_bit, 0);
        check("R1 wr_gate", wr_gate, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 timing_err", timing_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_sector(1'b1, 1'b0, 1'b0, 0, 8'hA5, 5'h13, 4'h9, 1'b1);
        check("R5 takes", take_cnt, 128);
        check("R9 no terr", terr_cnt, 0);
        check("R11 bit count", bits_seen, DSTART + 128*37 + 74);

        run_sector(1'b0, 1'b0, 1'b0, 0, 8'h3C, 5'h0A, 4'h6, 1'b0);
        check("R8 takes", take_cnt, 128);

        run_sector(1'b1, 1'b1, 1'b1, 2, 8'hFF, 5'h1F, 4'hF, 1'b0);
        check("R9 terr pulses", terr_cnt, 2);
        check("R9 takes", take_cnt, 126);

        run_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule